// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns stereo audio words into a serial bit stream on one data line, together with a bit clock and a frame clock. It either produces both clocks itself, dividing the system clock, or follows both clocks from an external source. The framing can be standard I2S, left-justified or right-justified. Each clock can be inverted on its own. All timing is handled in the system clock domain: external clocks are synchronized and their edges detected, and every output is a register.

Samples arrive on a valid/ready input, one word per active slot. Words are collected into a small buffer. The buffer is handed over at the start of each frame through a per-slot routing table, which sets the sample that each output slot carries. If the buffer is not complete at a frame start, the frame carries zeros and a sticky underrun flag is raised. A running count of transmitted samples can be cleared to zero.

Top module: `i2s_tx_serializer`

## Requirements
- R1: `fmt` selects framing; a frame is 64 bit periods made of two 32-bit slots. Slot 0 is the left channel. Code 0 is standard I2S: the frame clock is low for slot 0, and the word MSB sits one bit period after the slot starts. Code 1 is left-justified and code 2 is right-justified. In both of these, the frame clock is high for slot 0. Left-justified puts the MSB in the first bit period of the slot. Right-justified puts the LSB in the last bit period of the slot. Every other bit period of a slot is zero.
- R2: `bclk_inv` inverts the bit clock and `lrclk_inv` inverts the frame clock, at the pins in both directions. All four combinations give the same data stream relative to the effective clocks.
- R3: With `slave_mode`=0 the block drives both clocks (`clk_oe`=1), and the bit clock period is 2*HALF_DIV system cycles. With `slave_mode`=1, `clk_oe`=0 and the block follows `bclk_in` and `lrclk_in`.
- R4: Data and frame clock change only after a falling edge of the effective bit clock, so a receiver samples on the effective rising edge.
- R5: `glb_en`=0 clears the frame state, the buffer fill and the underrun flag, and holds `s_ready` low. `tx_en`=0 holds `s_ready` low, and later frames carry zeros without an underrun. `line_en`=0 forces `sdata` and `sdata_oe` to 0.
- R6: Slot n carries the buffered word whose index is in `chan_map[4n+3:4n]`. The value 8'h10 is identity and 8'h01 swaps the two words. An index that is not below the active count gives zero.
- R7: `slot_cnt_m1` holds the number of active slots minus one: 1 for stereo and 0 for one word per frame. Inactive slots carry zero.
- R8: `sent_cnt` grows by the active slot count at each frame start that loads a full buffer. `cnt_clr` sets it to zero and takes priority.
- R9: A frame start with an incomplete buffer while `tx_en`=1 sends an all-zero frame and sets `underrun`. The flag stays set until `glb_en` is low or reset.
- R10: A word accepted in the same cycle as a frame start does not count toward that frame. That frame underruns, and the word is carried in the next frame.
- R11: After reset with `glb_en`=0: `s_ready`=0, `sdata`=0, `sdata_oe`=0, `clk_oe`=0, `underrun`=0, `sent_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| line_en | input | 1 | Data line enable |
| slave_mode | input | 1 | 0 drive clocks, 1 follow clocks |
| fmt | input | 2 | Framing select |
| bclk_inv | input | 1 | Bit clock inversion |
| lrclk_inv | input | 1 | Frame clock inversion |
| slot_cnt_m1 | input | 1 | Active slots minus one |
| chan_map | input | 8 | Per-slot source index, 4 bits each |
| cnt_clr | input | 1 | Clear sample counter |
| s_data | input | 16 | Sample word |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with valid |
| bclk_in | input | 1 | External bit clock |
| lrclk_in | input | 1 | External frame clock |
| bclk_out | output | 1 | Generated bit clock |
| lrclk_out | output | 1 | Generated frame clock |
| clk_oe | output | 1 | Clock outputs driven |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Data line driven |
| underrun | output | 1 | Sticky underrun flag |
| sent_cnt | output | 32 | Samples transmitted |

## Verification
Two events can land in one cycle: acceptance of the word that completes the buffer, and the frame-start load that reads the buffer. The bench provokes this in follower mode. It drives the external clocks itself and counts the synchronizer cycles, so that the last word's valid lands on exactly the edge where the synchronized falling edge opening the left slot is acted on. The result is judged at the ports: that frame must be all zeros with `underrun` set, and the following frame must carry both words.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 4,
  parameter int MAP_W    = 4,
  parameter int CNT_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glb_en,
  input  logic                  tx_en,
  input  logic                  line_en,
  input  logic                  slave_mode,
  input  logic [1:0]            fmt,
  input  logic                  bclk_inv,
  input  logic                  lrclk_inv,
  input  logic [0:0]            slot_cnt_m1,
  input  logic [2*MAP_W-1:0]    chan_map,
  input  logic                  cnt_clr,
  input  logic [SAMPLE_W-1:0]   s_data,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic                  bclk_in,
  input  logic                  lrclk_in,
  output logic                  bclk_out,
  output logic                  lrclk_out,
  output logic                  clk_oe,
  output logic                  sdata,
  output logic                  sdata_oe,
  output logic                  underrun,
  output logic [CNT_W-1:0]      sent_cnt
);
  localparam int NSLOT   = 2;
  localparam int FRAME_B = NSLOT * SLOT_W;
  localparam int PW      = $clog2(FRAME_B);
  localparam int IW      = $clog2(NSLOT + 1);
  localparam int HW      = $clog2(HALF_DIV);
  localparam logic [1:0] FMT_STD = 2'd0, FMT_LJ = 2'd1, FMT_RJ = 2'd2;

  // external clock synchronizers and falling-edge detect
  logic [1:0] bsync, lsync;
  logic       b_prev;
  wire        b_eff_s  = bsync[1] ^ bclk_inv;
  wire        lr_eff_s = lsync[1] ^ lrclk_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsync <= '0; lsync <= '0; b_prev <= 1'b0;
    end else begin
      bsync <= {bsync[0], bclk_in};
      lsync <= {lsync[0], lrclk_in};
      b_prev <= b_eff_s;
    end
  end

  // master bit clock divider
  logic [HW-1:0] div_q;
  logic          bclk_q;
  wire div_wrap = (div_q == HW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0; bclk_q <= 1'b0;
    end else if (!glb_en || slave_mode) begin
      div_q <= '0; bclk_q <= 1'b0;
    end else begin
      div_q <= div_wrap ? '0 : div_q + 1'b1;
      if (div_wrap) bclk_q <= ~bclk_q;
    end
  end

  wire m_fall   = glb_en && !slave_mode && div_wrap && bclk_q;
  wire s_fall   = glb_en && slave_mode && b_prev && !b_eff_s;
  wire fall_evt = m_fall || s_fall;

  // frame position
  wire       left_lvl = (fmt != FMT_STD);
  wire       s_left   = (lr_eff_s == left_lvl);
  logic [PW-1:0] pos_q, pos_n;
  logic          left_prev, lr_q;

  always_comb begin
    pos_n = pos_q + 1'b1;
    if (slave_mode && (s_left != left_prev))
      pos_n = s_left ? '0 : PW'(SLOT_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !glb_en) begin
      pos_q <= '1; left_prev <= 1'b0; lr_q <= 1'b0;
    end else if (fall_evt) begin
      pos_q     <= pos_n;
      left_prev <= s_left;
      lr_q      <= (pos_n < PW'(SLOT_W)) ? left_lvl : ~left_lvl;
    end
  end

  // sample buffer and frame-start load
  logic [SAMPLE_W-1:0] buf_q [NSLOT];
  logic [SAMPLE_W-1:0] sh_q  [NSLOT];
  logic [SAMPLE_W-1:0] sh_n  [NSLOT];
  logic [IW-1:0]       fill_q;
  wire  [IW-1:0]       act  = IW'(slot_cnt_m1) + IW'(1);
  wire                 full = (fill_q >= act);
  wire                 ld   = fall_evt && (pos_n == '0);
  wire                 ld_ok = ld && tx_en && full;
  wire                 acc  = s_valid && s_ready;

  assign s_ready = glb_en && tx_en && !full;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wire [MAP_W-1:0] src = chan_map[g*MAP_W +: MAP_W];
    wire use_src = ld_ok && (IW'(g) < act) && (src < MAP_W'(act));
    assign sh_n[g] = ld ? (use_src ? buf_q[src[0]] : '0) : sh_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !glb_en) begin
      fill_q <= '0; underrun <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        buf_q[i] <= '0; sh_q[i] <= '0;
      end
    end else begin
      if (acc) begin
        buf_q[fill_q[0]] <= s_data;
        fill_q <= fill_q + 1'b1;
      end
      if (ld_ok) fill_q <= '0;
      if (ld && tx_en && !full) underrun <= 1'b1;
      for (int i = 0; i < NSLOT; i++) sh_q[i] <= sh_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sent_cnt <= '0;
    else if (cnt_clr) sent_cnt <= '0;
    else if (glb_en && ld_ok) sent_cnt <= sent_cnt + CNT_W'(act);
  end

  // bit selection
  logic lj_bit, rj_bit, lj_prev, sd_q;
  always_comb begin
    int q;
    logic [SAMPLE_W-1:0] w;
    q = int'(pos_n[PW-2:0]);
    w = sh_n[pos_n[PW-1]];
    lj_bit = 1'b0;
    rj_bit = 1'b0;
    if (q < SAMPLE_W) lj_bit = w[SAMPLE_W-1-q];
    if (q >= SLOT_W - SAMPLE_W) rj_bit = w[SLOT_W-1-q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !glb_en) begin
      lj_prev <= 1'b0; sd_q <= 1'b0;
    end else if (fall_evt) begin
      lj_prev <= lj_bit;
      case (fmt)
        FMT_STD: sd_q <= lj_prev;
        FMT_LJ:  sd_q <= lj_bit;
        FMT_RJ:  sd_q <= rj_bit;
        default: sd_q <= 1'b0;
      endcase
    end
  end

  assign bclk_out  = bclk_q ^ bclk_inv;
  assign lrclk_out = lr_q ^ lrclk_inv;
  assign clk_oe    = glb_en && !slave_mode;
  assign sdata     = sd_q && line_en;
  assign sdata_oe  = glb_en && line_en;

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && !fall_evt) |=> $stable(sd_q) && $stable(lr_q));

  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && m_fall && (pos_q == '1)) |=> (pos_q == '0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && glb_en) |=> underrun);

  p_underrun_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && ld && !full) |=> (sh_q[0] == '0) && (sh_q[1] == '0));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(glb_en && ld_ok)) |=> $stable(sent_cnt));

  p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= IW'(NSLOT));
endmodule

// File: tb/i2s_tx_serializer_test.sv
module i2s_tx_serializer_test;
  localparam int HB = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic glb_en = 0, tx_en = 0, line_en = 0, slave_mode = 0;
  logic [1:0] fmt = 0;
  logic bclk_inv = 0, lrclk_inv = 0;
  logic [0:0] slot_cnt_m1 = 1'b1;
  logic [7:0] chan_map = 8'h10;
  logic cnt_clr = 0;
  logic [15:0] s_data = 0;
  logic s_valid = 0, s_ready;
  logic bclk_in = 0, lrclk_in = 0;
  logic bclk_out, lrclk_out, clk_oe, sdata, sdata_oe, underrun;
  logic [31:0] sent_cnt;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2s_tx_serializer uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en), .line_en(line_en),
    .slave_mode(slave_mode), .fmt(fmt), .bclk_inv(bclk_inv), .lrclk_inv(lrclk_inv),
    .slot_cnt_m1(slot_cnt_m1), .chan_map(chan_map), .cnt_clr(cnt_clr),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
    .clk_oe(clk_oe), .sdata(sdata), .sdata_oe(sdata_oe), .underrun(underrun),
    .sent_cnt(sent_cnt));

  typedef struct packed {
    logic       slv;
    logic [1:0] f;
    logic       bi;
    logic       li;
    logic [7:0] map;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [15:0] ea;
    logic [15:0] eb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 8'h10, 16'hA5C3, 16'h1234, 16'hA5C3, 16'h1234},
    '{1'b0, 2'd1, 1'b1, 1'b0, 8'h10, 16'h8001, 16'h7FFE, 16'h8001, 16'h7FFE},
    '{1'b0, 2'd2, 1'b0, 1'b1, 8'h10, 16'hF00F, 16'h0FF0, 16'hF00F, 16'h0FF0},
    '{1'b0, 2'd0, 1'b1, 1'b1, 8'h01, 16'h1111, 16'hBEEF, 16'hBEEF, 16'h1111},
    '{1'b1, 2'd0, 1'b0, 1'b0, 8'h10, 16'hCAFE, 16'h0001, 16'hCAFE, 16'h0001},
    '{1'b1, 2'd1, 1'b1, 1'b1, 8'h01, 16'h4321, 16'h8765, 16'h8765, 16'h4321},
    '{1'b1, 2'd2, 1'b1, 1'b0, 8'h10, 16'hFFFF, 16'h8000, 16'hFFFF, 16'h8000},
    '{1'b1, 2'd2, 1'b0, 1'b1, 8'h00, 16'h5A5A, 16'h3C3C, 16'h5A5A, 16'h5A5A}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int data_off(input logic [1:0] f);
    return (f == 2'd0) ? 1 : (f == 2'd1) ? 0 : 16;
  endfunction

  function automatic logic [15:0] get_word(input logic [63:0] b, input logic [1:0] f, input int s);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[15-i] = b[s*32 + data_off(f) + i];
    return w;
  endfunction

  function automatic logic pad_ok(input logic [63:0] b, input logic [1:0] f);
    logic ok = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int q = 0; q < 32; q++)
        if ((q < data_off(f) || q >= data_off(f) + 16) && b[s*32+q]) ok = 1'b0;
    return ok;
  endfunction

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    s_data = w; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    glb_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic slave_idle();
    logic ll = (fmt != 2'd0);
    bclk_in = 1'b1 ^ bclk_inv;
    lrclk_in = ~ll ^ lrclk_inv;
    repeat (4) @(negedge clk);
  endtask

  task automatic slave_frame(input logic late, input logic [15:0] late_w, output logic [63:0] bits);
    logic ll = (fmt != 2'd0);
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      bclk_in = 1'b0 ^ bclk_inv;
      lrclk_in = ((p < 32) ? ll : ~ll) ^ lrclk_inv;
      for (int k = 1; k <= HB; k++) begin
        @(negedge clk);
        if (late && p == 0 && k == 2) begin s_data = late_w; s_valid = 1'b1; end
        if (late && p == 0 && k == 3) s_valid = 1'b0;
      end
      bclk_in = 1'b1 ^ bclk_inv;
      for (int k = 1; k <= HB; k++) begin
        @(negedge clk);
        if (k == 1) bits[p] = sdata;
      end
    end
  endtask

  task automatic master_frame(output logic [63:0] bits, output int period);
    logic ll = (fmt != 2'd0);
    logic pb;
    int t0 = 0;
    period = 0;
    @(negedge clk);
    while (((lrclk_out ^ lrclk_inv) == ll)) @(negedge clk);
    while (((lrclk_out ^ lrclk_inv) != ll)) @(negedge clk);
    pb = bclk_out ^ bclk_inv;
    for (int p = 0; p < 64; p++) begin
      forever begin
        @(negedge clk);
        if ((bclk_out ^ bclk_inv) && !pb) begin pb = 1'b1; break; end
        pb = bclk_out ^ bclk_inv;
      end
      bits[p] = sdata;
      if (p == 0) t0 = cyc;
      if (p == 1) period = cyc - t0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] bits;
    int per;
    logic [31:0] c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!s_ready && !sdata && !sdata_oe, "R11 ready/data/oe idle", {s_ready, sdata, sdata_oe}, 0);
    chk(!clk_oe && !underrun, "R11 clk_oe/underrun", {clk_oe, underrun}, 0);
    chk(sent_cnt == 0, "R11 sent_cnt", sent_cnt, 0);

    // vector table: R1 framing, R2 inversion, R3 role, R6 map
    for (int v = 0; v < NV; v++) begin
      restart();
      slave_mode = VECS[v].slv; fmt = VECS[v].f;
      bclk_inv = VECS[v].bi; lrclk_inv = VECS[v].li; chan_map = VECS[v].map;
      slot_cnt_m1 = 1'b1; tx_en = 1'b1; line_en = 1'b1;
      if (VECS[v].slv) begin
        slave_idle();
        glb_en = 1'b1;
        push(VECS[v].w0); push(VECS[v].w1);
        slave_frame(1'b0, 16'h0, bits);
        chk(clk_oe == 1'b0, "R3 follower clk_oe", clk_oe, 0);
      end else begin
        glb_en = 1'b1;
        push(VECS[v].w0); push(VECS[v].w1);
        push(VECS[v].w0); push(VECS[v].w1);
        master_frame(bits, per);
        chk(clk_oe == 1'b1, "R3 driver clk_oe", clk_oe, 1);
        chk(per == 8, "R3 bit clock period", per, 8);
      end
      chk(get_word(bits, fmt, 0) == VECS[v].ea, "R1/R2/R6 slot0 word", get_word(bits, fmt, 0), VECS[v].ea);
      chk(get_word(bits, fmt, 1) == VECS[v].eb, "R1/R2/R6 slot1 word", get_word(bits, fmt, 1), VECS[v].eb);
      chk(pad_ok(bits, fmt), "R1 zero padding", bits, 0);
    end

    // R8 counter clear and step, R9 underrun
    restart();
    slave_mode = 1'b1; fmt = 2'd0; bclk_inv = 0; lrclk_inv = 0; chan_map = 8'h10;
    @(negedge clk); cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    chk(sent_cnt == 0, "R8 clear", sent_cnt, 0);
    slave_idle(); glb_en = 1'b1;
    chk(!underrun, "R5 underrun cleared by global disable", underrun, 0);
    push(16'h0F0F); push(16'hF0F0);
    slave_frame(1'b0, 16'h0, bits);
    chk(sent_cnt == 2, "R8 step by two", sent_cnt, 2);
    slave_frame(1'b0, 16'h0, bits);
    chk(underrun == 1'b1, "R9 underrun set", underrun, 1);
    chk(bits == 0, "R9 zero frame", bits, 0);
    chk(sent_cnt == 2, "R8 no step on underrun", sent_cnt, 2);
    push(16'h1357); push(16'h2468);
    slave_frame(1'b0, 16'h0, bits);
    chk(underrun == 1'b1, "R9 sticky", underrun, 1);
    chk(get_word(bits, fmt, 0) == 16'h1357 && get_word(bits, fmt, 1) == 16'h2468,
        "R9 data after underrun", bits, 64'h0);

    // R10 last word accepted in the frame-start cycle
    restart(); slave_idle(); glb_en = 1'b1;
    push(16'hAAAA);
    slave_frame(1'b1, 16'h5555, bits);
    chk(underrun == 1'b1, "R10 underrun at same-cycle load", underrun, 1);
    chk(bits == 0, "R10 frame zero", bits, 0);
    slave_frame(1'b0, 16'h0, bits);
    chk(get_word(bits, fmt, 0) == 16'hAAAA, "R10 slot0 next frame", get_word(bits, fmt, 0), 16'hAAAA);
    chk(get_word(bits, fmt, 1) == 16'h5555, "R10 slot1 next frame", get_word(bits, fmt, 1), 16'h5555);

    // R5 line enable off
    restart(); line_en = 1'b0; slave_idle(); glb_en = 1'b1;
    push(16'hFFFF); push(16'hFFFF);
    slave_frame(1'b0, 16'h0, bits);
    chk(bits == 0 && !sdata_oe, "R5 line off", {bits[62:0], sdata_oe}, 0);

    // R5 transmit enable off
    restart(); line_en = 1'b1; tx_en = 1'b0; slave_idle(); glb_en = 1'b1;
    @(negedge clk);
    chk(!s_ready, "R5 tx off ready low", s_ready, 0);
    slave_frame(1'b0, 16'h0, bits);
    chk(bits == 0 && !underrun, "R5 tx off zeros no underrun", {bits[62:0], underrun}, 0);

    // R7 single active slot
    restart(); tx_en = 1'b1; fmt = 2'd1; slot_cnt_m1 = 1'b0; chan_map = 8'h10;
    slave_idle(); glb_en = 1'b1;
    c0 = sent_cnt;
    push(16'hC3A5);
    @(negedge clk);
    chk(!s_ready, "R7 buffer full after one word", s_ready, 0);
    slave_frame(1'b0, 16'h0, bits);
    chk(get_word(bits, fmt, 0) == 16'hC3A5, "R7 slot0 word", get_word(bits, fmt, 0), 16'hC3A5);
    chk(get_word(bits, fmt, 1) == 16'h0000, "R7 inactive slot zero", get_word(bits, fmt, 1), 0);
    chk(sent_cnt == c0 + 1, "R8 step by one", sent_cnt, c0 + 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule